// File: doc/BRIEF.md
# Parallel-Load Serial Shift Register

This block turns a word of parallel channel states into a serial bit stream. It is a parallel-in, serial-out register with a level-sensitive active-low load control, an active-low shift enable, a serial input and a serial output. It runs synchronously on the system clock. While the load control is low, every clock edge copies the parallel word into the register. While the load control is high and the enable is low, every clock edge moves the register one place toward the serial output. The bit on the serial input enters at the far end.

The highest channel leaves first, followed by the lower channels in descending order. After all of them, the bits that were taken in from the serial input follow. Several instances can be chained by wiring each serial output to the next serial input. A host then clocks out WIDTH bits per instance. At the end of a chain, the serial input is tied high so that ones fill the register.

Top module: `piso_serializer`

## Requirements
- R1: While rst_n is low at a rising clock edge, every stage is set to 1, so ser_out reads 1 in the cycle after that edge.
- R2: With load_n low at a rising edge, the register takes par_in, whatever the levels of shift_en_n and ser_in. Immediately after that edge, ser_out equals par_in[WIDTH-1].
- R3: With load_n high and shift_en_n low at a rising edge, every stage moves one place toward ser_out. After a load, ser_out therefore shows par_in[WIDTH-1], then par_in[WIDTH-2], down to par_in[0], with one bit per shift edge.
- R4: With load_n high and shift_en_n high at a rising edge, the register keeps its contents and ser_out does not change, whatever ser_in does.
- R5: A level on ser_in sampled at a shift edge appears on ser_out after exactly WIDTH shift edges, counting that edge. Hold cycles in between do not count toward the WIDTH.
- R6: While load_n stays low over several edges, the register follows par_in on each edge. The value from the last edge before load_n rises is the one that gets shifted out.
- R7: A load edge that arrives partway through a shift sequence discards the remaining bits. ser_out then restarts with the new par_in[WIDTH-1].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| load_n | input | 1 | Active-low load level; dominates the enable |
| shift_en_n | input | 1 | Active-low shift enable, used only while load_n is high |
| ser_in | input | 1 | Serial data entering the stage farthest from the output |
| par_in | input | WIDTH | Parallel channel states; bit WIDTH-1 is sent first |
| ser_out | output | 1 | Serial data from the last stage |

## Verification
A stage that holds a wrong value cannot be seen at once. It shows up on ser_out only after the shift edges that carry it to the last stage, which can take up to WIDTH-1 shifts. If a load or hold is decoded wrongly, the error shows on ser_out in the very next cycle. The reference model is therefore compared on every clock, over long random mixes of load, hold and shift. Shift runs longer than WIDTH drain every stage to the output, so no corrupted bit can stay hidden.

// File: rtl/pisoser_pkg.sv
// Shared types for the parallel-load serializer.
// Assumes: load control dominates the shift enable; both are active low.
package pisoser_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_SHIFT = 2'd1,
        OP_LOAD  = 2'd2
    } op_mode_e;

    // Resolve the two active-low controls into one operation.
    function automatic op_mode_e resolve_op(input logic load_n, input logic en_n);
        if (!load_n)
            return OP_LOAD;
        else if (!en_n)
            return OP_SHIFT;
        else
            return OP_HOLD;
    endfunction

endpackage

// File: rtl/pisoser_mode_dec.sv
// Control decoder: maps load_n / shift_en_n to one operation per cycle.
// Assumes the controls are already synchronous to clk.
module pisoser_mode_dec
    import pisoser_pkg::*;
(
    input  logic     load_n,
    input  logic     shift_en_n,
    output op_mode_e op
);

    // Load has priority over shift; neither active means hold.
    always_comb begin
        op = resolve_op(load_n, shift_en_n);
    end

endmodule

// File: rtl/pisoser_cell.sv
// One register stage: loads its parallel bit, takes its upstream
// neighbour on a shift, or keeps its value. Reset value is a parameter.
module pisoser_cell
    import pisoser_pkg::*;
#(
    parameter logic RST_VAL = 1'b1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  op_mode_e op,
    input  logic     par_bit,
    input  logic     prev_bit,
    output logic     q
);

    // Stage update per operation, synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else begin
            case (op)
                OP_LOAD:  q <= par_bit;
                OP_SHIFT: q <= prev_bit;
                default:  q <= q;
            endcase
        end
    end

endmodule

// File: rtl/piso_serializer.sv
// Parallel-in serial-out register with level load and active-low enable.
// Stage 0 takes ser_in; stage WIDTH-1 drives ser_out directly with no
// extra output flop. par_in[i] loads stage i, so bit WIDTH-1 leaves first.
module piso_serializer #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic             shift_en_n,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic             ser_out
);
    import pisoser_pkg::*;

    localparam int LAST = WIDTH - 1;

    op_mode_e         op;
    logic [WIDTH:0]   chain;

    pisoser_mode_dec u_dec (
        .load_n     (load_n),
        .shift_en_n (shift_en_n),
        .op         (op)
    );

    // Serial input feeds the head of the chain.
    assign chain[0] = ser_in;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        pisoser_cell #(.RST_VAL(1'b1)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .op       (op),
            .par_bit  (par_in[i]),
            .prev_bit (chain[i]),
            .q        (chain[i+1])
        );
    end

    // Output taken straight from the last stage.
    assign ser_out = chain[WIDTH];

    // R1: reset drives the output high on the next cycle
    p_reset_high_r1: assert property (@(posedge clk)
        !rst_n |=> ser_out);

    // R2: a load edge presents the top parallel bit immediately
    p_load_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> ser_out == $past(par_in[LAST]));

    // R3: a shift edge brings the upstream stage to the output
    p_shift_move_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !shift_en_n) |=> ser_out == $past(chain[LAST]));

    // R4: hold leaves the output unchanged
    p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && shift_en_n) |=> $stable(ser_out));

endmodule

// File: tb/piso_serializer_test.sv
`timescale 1ns/1ps
module piso_serializer_test;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_n = 1'b1;
    logic         shift_en_n = 1'b1;
    logic         ser_in = 1'b1;
    logic [W-1:0] par_in = '0;
    logic         ser_out;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    piso_serializer #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .shift_en_n(shift_en_n),
        .ser_in(ser_in), .par_in(par_in), .ser_out(ser_out)
    );

    // Behavioural reference: front of the queue is what ser_out must show.
    bit    model_q[$];
    string last_tag = "R1";
    bit    prev_load = 0;
    bit    prev_shift = 0;
    int    shifts_since_load = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            model_q.delete();
            for (int k = 0; k < W; k++) model_q.push_back(1'b1);
            last_tag = "R1";
            prev_load = 0;
            prev_shift = 0;
            shifts_since_load = 0;
        end else if (!load_n) begin
            model_q.delete();
            for (int k = W - 1; k >= 0; k--) model_q.push_back(par_in[k]);
            last_tag = prev_load ? "R6" : (prev_shift ? "R7" : "R2");
            prev_load = 1;
            prev_shift = 0;
            shifts_since_load = 0;
        end else if (!shift_en_n) begin
            void'(model_q.pop_front());
            model_q.push_back(ser_in);
            shifts_since_load++;
            last_tag = (shifts_since_load >= W) ? "R5" : "R3";
            prev_load = 0;
            prev_shift = 1;
        end else begin
            last_tag = "R4";
            prev_load = 0;
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at %0t: ser_out actual=%b expected=%b", tag, $time, act, exp);
        end
    endtask

    // Per-cycle comparison at the falling edge, after reset is applied once.
    bit started = 0;
    always @(negedge clk) begin
        if (started && !finished) check(last_tag, ser_out, model_q[0]);
    end

    task automatic step(input logic ld, input logic en, input logic si, input logic [W-1:0] p);
        @(negedge clk);
        load_n = ld; shift_en_n = en; ser_in = si; par_in = p;
    endtask

    initial begin
        // R1: reset state
        @(negedge clk); @(negedge clk);
        started = 1;
        @(negedge clk);
        check("R1", ser_out, 1'b1);
        rst_n = 1'b1;

        // R2: load with enable low and ser_in low; load must dominate
        step(1'b0, 1'b0, 1'b0, 8'hA5);
        // R3: shift out all bits with ser_in low, then R5 tail
        for (int k = 0; k < W + 4; k++) step(1'b1, 1'b0, 1'b0, 8'h00);
        // R4: hold while ser_in toggles
        for (int k = 0; k < 6; k++) step(1'b1, 1'b1, k[0], 8'hFF);
        // R6: load held low with changing inputs
        step(1'b0, 1'b1, 1'b0, 8'h0F);
        step(1'b0, 1'b1, 1'b0, 8'hF0);
        step(1'b0, 1'b0, 1'b1, 8'h81);
        // R3/R5 with idle-high serial input: ones follow the word
        for (int k = 0; k < W + 3; k++) step(1'b1, 1'b0, 1'b1, 8'h00);
        // R7: reload partway through a shift
        step(1'b0, 1'b1, 1'b0, 8'h3C);
        for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 1'b0, 8'h00);
        step(1'b0, 1'b0, 1'b0, 8'hC3);
        // R5 with holds interleaved between shifts
        for (int k = 0; k < 2 * W; k++) step(1'b1, k[0], ~k[1], 8'h00);
        // Random mix of all operations
        for (int k = 0; k < 400; k++) begin
            int r;
            r = $urandom_range(0, 9);
            step(r == 0 ? 1'b0 : 1'b1, r > 6 ? 1'b1 : 1'b0,
                 1'($urandom), W'($urandom));
        end
        // Reset again mid-stream (R1)
        step(1'b1, 1'b0, 1'b0, 8'h00);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        step(1'b1, 1'b1, 1'b0, 8'h00);
        @(negedge clk);
        check("R1", ser_out, 1'b1);
        @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule